// File: doc/BRIEF.md
# Registered Signed Complex Multiplier

This block forms the product of two complex numbers, (a + jb) and (c + jd). Each of the four parts is a small two's-complement integer. The block returns the real part and the imaginary part on separate result ports. A transform datapath can use it as the twiddle-multiply stage. It is placed between two register boundaries, so upstream logic only has to meet a single clock edge.

A bank of flip-flops samples the four operands on each rising clock edge. From that bank, a purely combinational path computes the four cross products with shift-and-add multipliers built on ripple-carry adders. The same adder structure forms the real difference by inverting its second input and forcing the carry-in high. A second bank of flip-flops captures both results and an overflow flag on the following rising edge. The two banks use no handshake. The block holds no state beyond these two banks, and a synchronous reset clears both.

Top module: `cplx_mul_reg`

## Requirements
- R1: The operands `op_a`, `op_b`, `op_c` and `op_d` are 4-bit two's-complement values with the sign in bit 3, so 4'b1000 is −8 and 4'b0111 is +7. Both results are 8-bit two's-complement values with the sign in bit 7.
- R2: Every cross product is exact for any mix of operand signs. For example, (−3)·6 presents −18 (8'hEE) and (−1)·1 presents −1 (8'hFF) when the other two operands are zero.
- R3: `re_o` equals a·c − b·d for every combination of operand values.
- R4: `im_o` equals b·c + a·d, reduced modulo 256.
- R5: Operands that are present at rising edge N appear on the outputs after rising edge N+1 and not before. The outputs change only at rising edges.
- R6: While `rst` is high at a rising edge, both banks clear, and after that edge all outputs read zero. At the first edge after `rst` falls, the outputs still read zero, because the input bank held zeros.
- R7: `ovf_o` is 1 exactly when a true result lies outside −128..+127. The only such case is a = b = c = d = −8. In that case `im_o` reads 8'h80 (wrapped +128), `re_o` reads 0, and `ovf_o` accompanies those results in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1 | Rising-edge clock for both register banks |
| rst  | input  | 1 | Synchronous active-high clear of both banks |
| op_a | input  | 4 | Real part of the first factor |
| op_b | input  | 4 | Imaginary part of the first factor |
| op_c | input  | 4 | Real part of the second factor |
| op_d | input  | 4 | Imaginary part of the second factor |
| re_o | output | 8 | Registered real result a·c − b·d |
| im_o | output | 8 | Registered imaginary result b·c + a·d |
| ovf_o | output | 1 | Registered flag: the true result did not fit 8 bits |

## Verification
The hardest condition to reach is the single overflow point: all four operands must sit at −8 at the same time, and the flag only means something if the bench tracks the latency. An exhaustive sweep over all 65536 operand combinations reaches it. The sweep drives a new vector each cycle and compares each output against an integer model two sample points later. A directed case then repeats the all-negative point and follows it with a reset while the outputs are nonzero. That reset shows that the clear takes effect at once and that the first edge after release still shows zeros.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

    // default operand width; result width follows as twice this
    parameter int unsigned CM_OPW = 4;
    localparam int unsigned CM_RW = 2 * CM_OPW;

    // adder mode selects plain sum or invert-and-carry difference
    typedef enum logic {
        CM_ADD = 1'b0,
        CM_SUB = 1'b1
    } cm_mode_e;

endpackage

// File: rtl/cmul_fa.sv
module cmul_fa (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);

    logic hx;

    always_comb begin
        hx = x ^ y;
        s  = hx ^ ci;
        co = (x & y) | (hx & ci);
    end

endmodule

// File: rtl/cmul_rca.sv
module cmul_rca
    import cmul_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  cm_mode_e     mode,
    output logic [W-1:0] s,
    output logic         ovf
);

    logic [W:0]   cy;
    logic [W-1:0] y_eff;
    logic         inv;

    always_comb begin
        inv   = (mode == CM_SUB);
        y_eff = y ^ {W{inv}};
        cy[0] = inv;
    end

    for (genvar k = 0; k < W; k++) begin : g_bit
        cmul_fa u_fa (
            .x  (x[k]),
            .y  (y_eff[k]),
            .ci (cy[k]),
            .s  (s[k]),
            .co (cy[k+1])
        );
    end

    // signed overflow: carry into sign stage differs from carry out
    always_comb ovf = cy[W] ^ cy[W-1];

    logic [W-1:0] arith_ref;
    always_comb begin
        arith_ref = (mode == CM_SUB) ? (x - y) : (x + y);
        // R3
        rca_sum_chk: assert (s == arith_ref);
    end

endmodule

// File: rtl/cmul_sam.sv
module cmul_sam
    import cmul_pkg::*;
#(
    parameter int unsigned OPW = CM_OPW,
    parameter int unsigned RW  = 2 * OPW
) (
    input  logic [OPW-1:0] mcand,
    input  logic [OPW-1:0] mplier,
    output logic [RW-1:0]  prod
);

    logic [RW-1:0]         ext;
    logic [OPW:0][RW-1:0]  acc;
    logic [OPW-1:0][RW-1:0] addend;
    logic [OPW-1:0]        stage_ovf;

    always_comb begin
        ext    = {{(RW-OPW){mcand[OPW-1]}}, mcand};
        acc[0] = '0;
    end

    // one ripple stage per multiplier bit; the sign bit's weight is negative
    for (genvar i = 0; i < OPW; i++) begin : g_stage
        localparam cm_mode_e MD = (i == OPW - 1) ? CM_SUB : CM_ADD;

        always_comb addend[i] = mplier[i] ? (ext << i) : '0;

        cmul_rca #(.W(RW)) u_add (
            .x    (acc[i]),
            .y    (addend[i]),
            .mode (MD),
            .s    (acc[i+1]),
            .ovf  (stage_ovf[i])
        );
    end

    always_comb prod = acc[OPW];

    logic signed [RW-1:0] prod_ref;
    always_comb begin
        prod_ref = $signed({{(RW-OPW){mcand[OPW-1]}}, mcand})
                 * $signed({{(RW-OPW){mplier[OPW-1]}}, mplier});
        // R2
        sam_prod_chk: assert (prod == prod_ref);
        // R2
        sam_stage_chk: assert (stage_ovf == '0);
    end

endmodule

// File: rtl/cplx_mul_reg.sv
module cplx_mul_reg
    import cmul_pkg::*;
#(
    parameter  int unsigned OPW = CM_OPW,
    localparam int unsigned RW  = 2 * OPW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] op_a,
    input  logic [OPW-1:0] op_b,
    input  logic [OPW-1:0] op_c,
    input  logic [OPW-1:0] op_d,
    output logic [RW-1:0]  re_o,
    output logic [RW-1:0]  im_o,
    output logic           ovf_o
);

    localparam int unsigned NPROD = 4;
    localparam logic [OPW-1:0] OP_MIN = {1'b1, {(OPW-1){1'b0}}};
    localparam logic [RW-1:0]  RS_MIN = {1'b1, {(RW-1){1'b0}}};

    // input bank
    logic [OPW-1:0] a_q, b_q, c_q, d_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
            c_q <= '0;
            d_q <= '0;
        end else begin
            a_q <= op_a;
            b_q <= op_b;
            c_q <= op_c;
            d_q <= op_d;
        end
    end

    // product pairing: 0 a*c, 1 b*d, 2 b*c, 3 a*d
    logic [NPROD-1:0][OPW-1:0] mc, mp;
    logic [NPROD-1:0][RW-1:0]  pp;

    always_comb begin
        mc[0] = a_q; mp[0] = c_q;
        mc[1] = b_q; mp[1] = d_q;
        mc[2] = b_q; mp[2] = c_q;
        mc[3] = a_q; mp[3] = d_q;
    end

    for (genvar p = 0; p < NPROD; p++) begin : g_prod
        cmul_sam #(.OPW(OPW), .RW(RW)) u_sam (
            .mcand  (mc[p]),
            .mplier (mp[p]),
            .prod   (pp[p])
        );
    end

    logic [RW-1:0] re_d, im_d;
    logic          re_ov, im_ov;

    cmul_rca #(.W(RW)) u_re (
        .x    (pp[0]),
        .y    (pp[1]),
        .mode (CM_SUB),
        .s    (re_d),
        .ovf  (re_ov)
    );

    cmul_rca #(.W(RW)) u_im (
        .x    (pp[2]),
        .y    (pp[3]),
        .mode (CM_ADD),
        .s    (im_d),
        .ovf  (im_ov)
    );

    // output bank
    always_ff @(posedge clk) begin
        if (rst) begin
            re_o  <= '0;
            im_o  <= '0;
            ovf_o <= 1'b0;
        end else begin
            re_o  <= re_d;
            im_o  <= im_d;
            ovf_o <= re_ov | im_ov;
        end
    end

    // R6
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (re_o == '0 && im_o == '0 && !ovf_o));

    // R7
    ovf_val_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> (im_o == RS_MIN && re_o == '0));

    // R7
    ovf_src_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> $past(a_q == OP_MIN && b_q == OP_MIN && c_q == OP_MIN && d_q == OP_MIN));

    // R5
    zero_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (a_q == '0 && b_q == '0) |=> (re_o == '0 && im_o == '0 && !ovf_o));

endmodule

// File: tb/sim_cplx_mul_reg.sv
module sim_cplx_mul_reg;

    logic       clk;
    logic       rst;
    logic [3:0] op_a, op_b, op_c, op_d;
    logic [7:0] re_o, im_o;
    logic       ovf_o;

    int checks;
    int errors;

    cplx_mul_reg u0 (
        .clk   (clk),
        .rst   (rst),
        .op_a  (op_a),
        .op_b  (op_b),
        .op_c  (op_c),
        .op_d  (op_d),
        .re_o  (re_o),
        .im_o  (im_o),
        .ovf_o (ovf_o)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    function automatic int sx(input logic [3:0] v);
        return int'($signed(v));
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] a, input logic [3:0] b,
                         input logic [3:0] c, input logic [3:0] d);
        op_a = a; op_b = b; op_c = c; op_d = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        checks = 0;
        errors = 0;
        rst = 1'b1;
        drive(4'h0, 4'h0, 4'h0, 4'h0);
        repeat (3) @(negedge clk);
        // R6 reset state
        chk("R6 re", re_o, 8'h00);
        chk("R6 im", im_o, 8'h00);
        chk("R6 ovf", {7'b0, ovf_o}, 8'h00);

        // R2 / R5: (-3)*6 with b=d=0
        rst = 1'b0;
        drive(4'hD, 4'h0, 4'h6, 4'h0);
        @(negedge clk);
        chk("R5 not yet re", re_o, 8'h00);
        chk("R5 not yet im", im_o, 8'h00);
        drive(4'hF, 4'h0, 4'h1, 4'h0);
        @(negedge clk);
        chk("R2 -3x6", re_o, 8'hEE);
        chk("R2 im zero", im_o, 8'h00);
        @(negedge clk);
        chk("R2 -1x1", re_o, 8'hFF);

        // R1 R3 R4 R7: exhaustive sweep, one vector per cycle
        for (int i = 0; i < 65536 + 2; i++) begin
            if (i >= 2) begin
                int v, ea, eb, ec, ed, er, ei;
                logic [15:0] w;
                v  = i - 2;
                w  = v[15:0];
                ea = sx(w[15:12]); eb = sx(w[11:8]);
                ec = sx(w[7:4]);   ed = sx(w[3:0]);
                er = ea * ec - eb * ed;
                ei = eb * ec + ea * ed;
                chk("R3 re", re_o, er[7:0]);
                chk("R4 im", im_o, ei[7:0]);
                chk("R7 ovf", {7'b0, ovf_o},
                    ((ei > 127 || ei < -128 || er > 127 || er < -128) ? 8'h01 : 8'h00));
            end
            if (i < 65536) begin
                logic [15:0] u;
                u = i[15:0];
                drive(u[15:12], u[11:8], u[7:4], u[3:0]);
            end
            @(negedge clk);
        end

        // R7 directed: all operands at -8 (4'b1000)
        drive(4'h8, 4'h8, 4'h8, 4'h8);
        repeat (2) @(negedge clk);
        chk("R7 im wrap", im_o, 8'h80);
        chk("R7 re", re_o, 8'h00);
        chk("R7 flag", {7'b0, ovf_o}, 8'h01);

        // R6: reset while outputs are nonzero
        rst = 1'b1;
        @(negedge clk);
        chk("R6 mid re", re_o, 8'h00);
        chk("R6 mid im", im_o, 8'h00);
        chk("R6 mid ovf", {7'b0, ovf_o}, 8'h00);
        rst = 1'b0;
        drive(4'h1, 4'h0, 4'h1, 4'h0);
        @(negedge clk);
        chk("R6 first edge re", re_o, 8'h00);
        @(negedge clk);
        chk("R5 after release re", re_o, 8'h01);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule